// File: doc/BRIEF.md
# Read-to-Write Turnaround Command Scheduler

This block sits on the host side of a burst-of-two DDR SRAM interface. It takes read and write requests through a valid/ready handshake and turns each accepted request into one command slot: an active-low load strobe, a read/write select and an address. Reads can follow reads, and writes can follow writes, in every slot. A write may follow a read only after enough idle slots have passed for the data bus to change direction without contention. A static configuration input sets that gap to two or three slots.

A write request carries two data words and two byte-enable masks. In the slot after the write command, the block presents both beats together with a valid flag. A downstream DDR output stage then drives beat 0 on the rising edge of the forward clock and beat 1 on the following falling edge. Capturing read data and the memory array itself belong to other blocks.

Top module: `ddr_turnaround_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_ld_n` is 1, `wd_valid` is 0 and `req_ready` is 1 when no write is requested.
- R2: Read requests presented in consecutive cycles are accepted with no stall and issued in consecutive slots.
- R3: Write requests presented in consecutive cycles, with no read before them inside the gap window, are issued in consecutive slots.
- R4: With `cfg_three_nop` = 0, a write that follows a read is issued with exactly two NOP slots between the two commands.
- R5: With `cfg_three_nop` = 1, a write that follows a read is issued with exactly three NOP slots between the two commands.
- R6: A read that follows a write is issued in the very next slot, with no NOP.
- R7: A slot with no accepted request is a NOP (`cmd_ld_n` = 1). Slots left idle by the host count toward the turnaround gap, so a write that arrives after enough idle slots does not stall.
- R8: In the cycle after a write command, `wd_valid` is 1 and `wd_beat0`/`wd_beat1` and `wd_en0`/`wd_en1` equal the request's word 0, word 1 and byte enables. Enable bit i, when 1, writes bits [9i+8:9i] of its beat. In every other cycle `wd_valid` is 0 and both enable outputs are 0.
- R9: A command slot carries `cmd_rw` = 1 for a read and 0 for a write, and `cmd_addr` equals the accepted request's address.
- R10: While turnaround NOPs are being counted, `req_ready` is 0 for the pending write. The write is issued once the gap is met, and the number of stalled cycles equals the number of NOPs still owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command slot clock (forward clock rising edge) |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_three_nop | input | 1 | 1 selects three turnaround NOPs, 0 selects two |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Burst address |
| req_wdata0 | input | DATA_W | Write word for beat 0 |
| req_wdata1 | input | DATA_W | Write word for beat 1 |
| req_wen0 | input | BYTES | Byte enables for beat 0 |
| req_wen1 | input | BYTES | Byte enables for beat 1 |
| cmd_ld_n | output | 1 | Active-low load strobe; high means NOP |
| cmd_rw | output | 1 | 1 read, 0 write |
| cmd_addr | output | ADDR_W | Command address |
| wd_valid | output | 1 | Write beats present this cycle |
| wd_beat0 | output | DATA_W | Word for the rising-edge beat |
| wd_beat1 | output | DATA_W | Word for the falling-edge beat |
| wd_en0 | output | BYTES | Byte enables for beat 0 |
| wd_en1 | output | BYTES | Byte enables for beat 1 |

## Verification
The hardest case to reach is a write that arrives partway through a turnaround gap. In that case some of the owed NOPs come from host idle slots and the rest from stalls, and the two have to add up to exactly the configured gap. The bench produces this by issuing a read, leaving the request lines idle for a chosen number of cycles and then presenting a write. It then checks the stall count and the slot spacing in both gap settings. Every command and beat is logged at the falling clock edge, so slot spacing is measured directly from the trace.

// File: rtl/ddr_turnaround_sched.sv
module ddr_turnaround_sched #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 18,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_three_nop,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata0,
  input  logic [DATA_W-1:0] req_wdata1,
  input  logic [BYTES-1:0]  req_wen0,
  input  logic [BYTES-1:0]  req_wen1,
  output logic              cmd_ld_n,
  output logic              cmd_rw,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wd_valid,
  output logic [DATA_W-1:0] wd_beat0,
  output logic [DATA_W-1:0] wd_beat1,
  output logic [BYTES-1:0]  wd_en0,
  output logic [BYTES-1:0]  wd_en1
);
  localparam int GAP_W = 2;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic              rd_open;
  logic [GAP_W-1:0]  idle_cnt;
  logic [DATA_W-1:0] hold_d0, hold_d1;
  logic [BYTES-1:0]  hold_e0, hold_e1;

  wire [GAP_W-1:0] gap_need = cfg_three_nop ? 2'd3 : 2'd2;
  wire wr_ok   = !rd_open || (idle_cnt >= gap_need);
  assign req_ready = !req_write || wr_ok;
  wire fire    = req_valid && req_ready;
  wire wr_slot = !cmd_ld_n && !cmd_rw;
  wire rd_slot = !cmd_ld_n && cmd_rw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_ld_n <= 1'b1;
      cmd_rw   <= 1'b1;
      cmd_addr <= '0;
      rd_open  <= 1'b0;
      idle_cnt <= '0;
      hold_d0  <= '0;
      hold_d1  <= '0;
      hold_e0  <= '0;
      hold_e1  <= '0;
      wd_valid <= 1'b0;
      wd_beat0 <= '0;
      wd_beat1 <= '0;
      wd_en0   <= '0;
      wd_en1   <= '0;
    end else begin
      cmd_ld_n <= !fire;
      if (fire) begin
        cmd_rw   <= !req_write;
        cmd_addr <= req_addr;
      end
      if (fire && req_write) begin
        hold_d0 <= req_wdata0;
        hold_d1 <= req_wdata1;
        hold_e0 <= req_wen0;
        hold_e1 <= req_wen1;
      end
      if (fire && !req_write) begin
        rd_open  <= 1'b1;
        idle_cnt <= '0;
      end else if (fire) begin
        rd_open  <= 1'b0;
      end else if (idle_cnt != GAP_MAX) begin
        idle_cnt <= idle_cnt + 1'b1;
      end
      wd_valid <= wr_slot;
      wd_en0   <= wr_slot ? hold_e0 : '0;
      wd_en1   <= wr_slot ? hold_e1 : '0;
      if (wr_slot) begin
        wd_beat0 <= hold_d0;
        wd_beat1 <= hold_d1;
      end
    end
  end

  // R4
  rd_wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_slot |-> !$past(rd_slot, 1) && !$past(rd_slot, 2));

  // R5
  rd_wr_gap3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_slot && cfg_three_nop && $past(cfg_three_nop, 3)) |-> !$past(rd_slot, 3));

  // R7
  slot_follows_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ld_n == !$past(req_valid && req_ready));

  // R8
  beats_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_valid |-> $past(!cmd_ld_n && !cmd_rw));

  // R6
  read_never_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> req_ready);
endmodule

// File: tb/ddr_turnaround_sched_tb.sv
module ddr_turnaround_sched_tb_top;
  localparam int AW = 21, DW = 18, BW = 2, LOGN = 1024;

  logic clk = 0, rst_n = 0, cfg3 = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] d0 = '0, d1 = '0;
  logic [BW-1:0] e0 = '0, e1 = '0;
  logic req_ready, ld_n, rw, wdv;
  logic [AW-1:0] caddr;
  logic [DW-1:0] b0, b1;
  logic [BW-1:0] en0, en1;

  ddr_turnaround_sched #(.ADDR_W(AW), .DATA_W(DW), .BYTES(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_three_nop(cfg3),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata0(d0), .req_wdata1(d1),
    .req_wen0(e0), .req_wen1(e1),
    .cmd_ld_n(ld_n), .cmd_rw(rw), .cmd_addr(caddr),
    .wd_valid(wdv), .wd_beat0(b0), .wd_beat1(b1), .wd_en0(en0), .wd_en1(en1));

  always #2 clk = ~clk;

  int total = 0, fails = 0, cyc = 0;
  logic          l_ld[LOGN];
  logic          l_rw[LOGN];
  logic [AW-1:0] l_ad[LOGN];
  logic          l_wv[LOGN];
  logic [DW-1:0] l_b0[LOGN], l_b1[LOGN];
  logic [BW-1:0] l_e0[LOGN], l_e1[LOGN];
  int cidx[8];
  int ncmd;

  always @(negedge clk) begin
    if (cyc < LOGN) begin
      l_ld[cyc] = ld_n; l_rw[cyc] = rw; l_ad[cyc] = caddr; l_wv[cyc] = wdv;
      l_b0[cyc] = b0; l_b1[cyc] = b1; l_e0[cyc] = en0; l_e1[cyc] = en1;
    end
    cyc = cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input bit wr, input int a, output int stalls);
    stalls = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a[AW-1:0];
    d0 = DW'(a * 3 + 1); d1 = DW'(a * 5 + 2);
    e0 = BW'(a); e1 = BW'(a + 1);
    #1;
    while (!req_ready) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic collect(input int from);
    ncmd = 0;
    for (int i = from; i < cyc && i < LOGN; i++)
      if (!l_ld[i] && ncmd < 8) begin cidx[ncmd] = i; ncmd++; end
  endtask

  task automatic t_reset;
    #1;
    chk(ld_n == 1, "R1 ld_n in reset", ld_n, 1);
    chk(wdv == 0, "R1 wd_valid in reset", wdv, 0);
    chk(req_ready == 1, "R1 ready in reset", req_ready, 1);
  endtask

  task automatic t_reads;
    int s, st0, st1, st2;
    s = cyc;
    send(0, 100, st0); send(0, 101, st1); send(0, 102, st2); idle(4);
    collect(s);
    chk(st0 + st1 + st2 == 0, "R2 read stalls", st0 + st1 + st2, 0);
    chk(ncmd == 3, "R2 read count", ncmd, 3);
    if (ncmd == 3) begin
      chk(cidx[2] - cidx[0] == 2, "R2 consecutive reads", cidx[2] - cidx[0], 2);
      for (int k = 0; k < 3; k++) begin
        chk(l_rw[cidx[k]] == 1, "R9 read rw", l_rw[cidx[k]], 1);
        chk(l_ad[cidx[k]] == AW'(100 + k), "R9 read addr", int'(l_ad[cidx[k]]), 100 + k);
      end
    end
  endtask

  task automatic t_writes;
    int s, st;
    s = cyc;
    for (int k = 0; k < 3; k++) begin
      send(1, 200 + k, st);
      chk(st == 0, "R3 write stall", st, 0);
    end
    idle(4);
    collect(s);
    chk(ncmd == 3, "R3 write count", ncmd, 3);
    if (ncmd == 3) begin
      chk(cidx[2] - cidx[0] == 2, "R3 consecutive writes", cidx[2] - cidx[0], 2);
      for (int k = 0; k < 3; k++) begin
        int a = 200 + k, j = cidx[k] + 1;
        chk(l_rw[cidx[k]] == 0, "R9 write rw", l_rw[cidx[k]], 0);
        chk(l_ad[cidx[k]] == AW'(a), "R9 write addr", int'(l_ad[cidx[k]]), a);
        chk(l_wv[j] == 1, "R8 wd_valid", l_wv[j], 1);
        chk(l_b0[j] == DW'(a * 3 + 1), "R8 beat0", int'(l_b0[j]), a * 3 + 1);
        chk(l_b1[j] == DW'(a * 5 + 2), "R8 beat1", int'(l_b1[j]), a * 5 + 2);
        chk(l_e0[j] == BW'(a), "R8 en0", int'(l_e0[j]), int'(BW'(a)));
        chk(l_e1[j] == BW'(a + 1), "R8 en1", int'(l_e1[j]), int'(BW'(a + 1)));
      end
      chk(l_wv[cidx[2] + 2] == 0 && l_e0[cidx[2] + 2] == 0, "R8 idle beats",
          l_wv[cidx[2] + 2], 0);
    end
  endtask

  task automatic t_rd_wr(input bit three, input int pre_idle, input string req);
    int s, st, sw, need, gap;
    cfg3 = three; need = three ? 3 : 2;
    s = cyc;
    send(0, 300, st);
    if (pre_idle > 0) idle(pre_idle);
    send(1, 301, sw);
    idle(5);
    collect(s);
    chk(ncmd == 2, {req, " cmd count"}, ncmd, 2);
    if (ncmd == 2) begin
      gap = cidx[1] - cidx[0] - 1;
      chk(gap == need, {req, " NOP gap"}, gap, need);
      chk(l_rw[cidx[1]] == 0, {req, " write after gap"}, l_rw[cidx[1]], 0);
    end
    chk(sw == (need > pre_idle ? need - pre_idle : 0), {req, " R10 stalls"}, sw,
        need > pre_idle ? need - pre_idle : 0);
    cfg3 = 0;
  endtask

  task automatic t_wr_rd;
    int s, st;
    s = cyc;
    send(1, 400, st); send(0, 401, st);
    chk(st == 0, "R6 read stall", st, 0);
    idle(4);
    collect(s);
    chk(ncmd == 2, "R6 cmd count", ncmd, 2);
    if (ncmd == 2) chk(cidx[1] - cidx[0] == 1, "R6 no gap", cidx[1] - cidx[0], 1);
  endtask

  task automatic t_empty;
    int s;
    s = cyc;
    idle(3);
    collect(s);
    chk(ncmd == 0, "R7 empty slots are NOP", ncmd, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1;
    #1 chk(ld_n == 1 && wdv == 0, "R1 after reset", ld_n, 1);
    t_reads();
    t_writes();
    t_rd_wr(0, 0, "R4");
    t_rd_wr(1, 0, "R5");
    t_rd_wr(0, 2, "R7 idle counts");
    t_rd_wr(1, 2, "R7 R5 partial idle");
    t_rd_wr(1, 1, "R10 partial idle");
    t_wr_rd();
    t_empty();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #20000;
    total++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule